// File: doc/BRIEF.md
# Converter Interrupt Aggregator

This block gathers the five interrupt requests of a data-converter subsystem (supply brownout, pen-down, end of measurement sequence, FIFO fill-level watermark and FIFO overrun) and makes each one sticky in a status register. Four of the five pass through a software-controlled enable mask. The enabled, latched requests merge into one combined interrupt line. Brownout is never masked. It also drives a line of its own, and its live, unlatched input level can be read at any time.

Software uses a small register port with a 2-bit address, a write strobe, 5-bit write data and combinational 16-bit read data. The addresses are 0 for the enable mask, 1 for the latched status, 2 for the live input levels and 3 for write-one-to-clear, which reads as zero. A write takes effect on the clock edge where the strobe is high. Reads reflect the current state. Every source uses the same bit position in the mask, status and clear registers and in the low bits of the live register: bit 0 brownout, bit 1 pen, bit 2 end of sequence, bit 3 watermark, bit 4 overrun. The source inputs are synchronous digital levels.

Top module: `conv_irq_agg`

## Requirements
- R1: After reset the status and mask registers read zero, and both interrupt outputs are low.
- R2: A source that is high at a clock edge sets its status bit (bit 0 brownout, 1 pen, 2 end of sequence, 3 watermark, 4 overrun), and the bit reads high after that edge.
- R3: A status bit stays high after its source falls, until software clears it.
- R4: Writing a one to a bit of address 3 clears that status bit at the write edge. Zero bits in the write leave the status unchanged.
- R5: When a source is high at the same edge as its clear, the status bit stays high.
- R6: Mask bits 4..1 at address 0 are writable, and a one enables that source. Bit 0 always reads zero and ignores writes.
- R7: `irq_o` is high exactly when some latched status bit is high and enabled. Brownout counts as always enabled.
- R8: Writing the mask never changes the status register, and status reads return latched bits whether or not they are enabled.
- R9: `bo_irq_o` follows the latched brownout status bit regardless of the mask, and ignores the other sources.
- R10: Address 2 returns the current input levels in bits 4..0, and the current brownout input also appears at bit 9.
- R11: Once a brownout status bit has been cleared, a brownout input present at the following edge sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| brownout_i | input | 1 | Brownout request level |
| pen_i | input | 1 | Pen-down request level |
| eos_i | input | 1 | End-of-sequence request level |
| wmark_i | input | 1 | FIFO watermark request level |
| ovrun_i | input | 1 | FIFO overrun request level |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 5 | Write data |
| reg_rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Combined interrupt |
| bo_irq_o | output | 1 | Dedicated brownout interrupt |

## Verification
The bench clears a status bit while its source is still high. A design that lets the clear win would drop a request that is still pending. It turns the mask off while a bit is latched. A design that ties masking to the status register would lose that bit when read back. It raises brownout with every mask bit at zero, the edge where an implementation that masks brownout would keep both lines low. It re-asserts brownout on the edge right after a clear, and a design with an extra cycle of clear latency would miss that request.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned SRC_BO  = 0;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_STAT = 2'd1,
    REG_RAW  = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni)        q <= 1'b0;
      else if (src_i[g])  q <= 1'b1;   // set has priority over clear
      else if (clr_i[g])  q <= 1'b0;
    end
    assign stat_o[g] = q;

    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(src_i[g])) |-> stat_o[g]);
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(stat_o[g]) && !$past(clr_i[g])) |-> stat_o[g]);
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(clr_i[g]) && !$past(src_i[g])) |-> !stat_o[g]);
  end
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int unsigned N          = 5,
  parameter int unsigned DW         = 16,
  parameter int unsigned RAW_BO_BIT = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  stat_i,
  input  logic [N-1:0]  raw_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned MW = N - 1;

  reg_sel_e       sel;
  logic [MW-1:0]  mask_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                       mask_q <= '0;
    else if (wr_i && sel == REG_MASK)  mask_q <= wdata_i[N-1:1];
  end

  assign en_o  = {mask_q, 1'b1};
  assign clr_o = (wr_i && sel == REG_CLR) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_MASK: rdata_o[N-1:0] = {mask_q, 1'b0};
      REG_STAT: rdata_o[N-1:0] = stat_i;
      REG_RAW: begin
        rdata_o[N-1:0]      = raw_i;
        rdata_o[RAW_BO_BIT] = raw_i[SRC_BO];
      end
      default:  rdata_o = '0;
    endcase
  end

  p_clr_only_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_o) |-> wr_i);
  p_mask_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(wr_i)) |-> $stable(en_o));
endmodule

// File: rtl/intr_combine.sv
module intr_combine
  import intr_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o,
  output logic         bo_irq_o
);
  assign irq_o    = |(stat_i & en_i);
  assign bo_irq_o = stat_i[SRC_BO];

  p_bo_in_combined_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_irq_o |-> irq_o);
  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i == '0) |-> !irq_o);
endmodule

// File: rtl/conv_irq_agg.sv
module conv_irq_agg
  import intr_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned RAW_BO_BIT = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                brownout_i,
  input  logic                pen_i,
  input  logic                eos_i,
  input  logic                wmark_i,
  input  logic                ovrun_i,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [NUM_SRC-1:0]  reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                irq_o,
  output logic                bo_irq_o
);
  logic [NUM_SRC-1:0] src, stat, en, clr;

  assign src = {ovrun_i, wmark_i, eos_i, pen_i, brownout_i};

  intr_status_bank #(.N(NUM_SRC)) u_bank (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .src_i (src),   .clr_i  (clr),   .stat_o (stat)
  );

  intr_regs #(.N(NUM_SRC), .DW(DW), .RAW_BO_BIT(RAW_BO_BIT)) u_regs (
    .clk_i  (clk_i),      .rst_ni  (rst_ni),
    .addr_i (reg_addr_i), .wr_i    (reg_wr_i), .wdata_i (reg_wdata_i),
    .stat_i (stat),       .raw_i   (src),
    .en_o   (en),         .clr_o   (clr),      .rdata_o (reg_rdata_o)
  );

  intr_combine #(.N(NUM_SRC)) u_comb (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .stat_i (stat), .en_i (en),
    .irq_o (irq_o), .bo_irq_o (bo_irq_o)
  );

  p_bo_unmaskable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(brownout_i)) |-> (bo_irq_o && irq_o));
endmodule

// File: tb/tb_conv_irq_agg.sv
module tb_conv_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [4:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq, bo_irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  conv_irq_agg dut (
    .clk_i (clk), .rst_ni (rst_n),
    .brownout_i (src[0]), .pen_i (src[1]), .eos_i (src[2]),
    .wmark_i (src[3]), .ovrun_i (src[4]),
    .reg_addr_i (addr), .reg_wr_i (wr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq), .bo_irq_o (bo_irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [4:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rst_n = 1'b0; src = '0; repeat (3) tick(); rst_n = 1'b1;
    rd(2'd1, d); chk("R1 status", d, 16'h0);
    rd(2'd0, d); chk("R1 mask", d, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 bo_irq", {15'b0, bo_irq}, 16'h0);
  endtask

  task automatic t_latch_each();
    logic [15:0] d;
    for (int i = 0; i < 5; i++) begin
      src = 5'(1 << i); tick(); src = '0;
      rd(2'd1, d); chk("R2 latch", d, 16'(1 << i));
      wreg(2'd3, 5'h1f);
      rd(2'd1, d); chk("R4 clear all", d, 16'h0);
    end
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    src = 5'h02; tick(); src = '0; repeat (3) tick();
    rd(2'd1, d); chk("R3 sticky", d, 16'h0002);
    chk("R7 masked pen no irq", {15'b0, irq}, 16'h0);
    wreg(2'd3, 5'h00);
    rd(2'd1, d); chk("R4 zero write no effect", d, 16'h0002);
    wreg(2'd3, 5'h1d);
    rd(2'd1, d); chk("R4 other bits no effect", d, 16'h0002);
    wreg(2'd3, 5'h02);
    rd(2'd1, d); chk("R4 clear pen", d, 16'h0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    src = 5'h04; tick();
    wreg(2'd3, 5'h04);
    rd(2'd1, d); chk("R5 set beats clear", d, 16'h0004);
    src = '0; wreg(2'd3, 5'h04);
    rd(2'd1, d); chk("R5 cleared after drop", d, 16'h0);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wreg(2'd0, 5'h1f);
    rd(2'd0, d); chk("R6 mask bit0 reads zero", d, 16'h001e);
    chk("R7 no status no irq", {15'b0, irq}, 16'h0);
    src = 5'h10; tick(); src = '0;
    chk("R7 enabled overrun irq", {15'b0, irq}, 16'h1);
    chk("R9 bo_irq ignores overrun", {15'b0, bo_irq}, 16'h0);
    wreg(2'd0, 5'h00);
    rd(2'd1, d); chk("R8 mask write keeps status", d, 16'h0010);
    chk("R7 disabled overrun no irq", {15'b0, irq}, 16'h0);
    src = 5'h01; tick(); src = '0;
    chk("R9 bo_irq unmasked", {15'b0, bo_irq}, 16'h1);
    chk("R7 brownout always enabled", {15'b0, irq}, 16'h1);
    wreg(2'd3, 5'h1f);
    chk("R9 bo_irq after clear", {15'b0, bo_irq}, 16'h0);
  endtask

  task automatic t_raw();
    logic [15:0] d;
    src = 5'h15; rd(2'd2, d); chk("R10 raw with brownout", d, 16'h0215);
    src = 5'h0a; rd(2'd2, d); chk("R10 raw without brownout", d, 16'h000a);
    src = '0;    rd(2'd2, d); chk("R10 raw idle", d, 16'h0);
    rd(2'd3, d); chk("R4 clear reads zero", d, 16'h0);
  endtask

  task automatic t_relatch();
    logic [15:0] d;
    src = 5'h01; tick(); src = '0;
    wreg(2'd3, 5'h01);
    rd(2'd1, d); chk("R11 cleared", d, 16'h0);
    src = 5'h01; tick(); src = '0;
    rd(2'd1, d); chk("R11 relatched next edge", d, 16'h0001);
    chk("R11 bo_irq back", {15'b0, bo_irq}, 16'h1);
    wreg(2'd3, 5'h1f);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latch_each();
    t_sticky();
    t_set_wins();
    t_mask();
    t_raw();
    t_relatch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule